// File: doc/BRIEF.md
# Dual-Counter Watchdog Timer

This block supervises software with two independent down-counters that share one clock and one register-mapped slave port. The narrower counter is the early warning: when it runs out it raises a level interrupt and pulls an active-low output low, which the chip can route to a pin. The wider counter is the last resort: when it runs out it pulls an active-low reset request low for the chip's reset logic.

Software programs a reload value for each counter. It then starts, stops or reloads the counters through one control register, and can read back the live counts and the expiry flags at any time. The wide counter is four bits wider than the bus. Software supplies only its upper 32 bits, and the low four bits of every reload are forced to ones, so its shortest period is sixteen clocks. An expired counter parks at zero with its output held until software reloads or restarts it.

The bus side is a single-cycle access: a write takes effect on the clock edge where select, enable and write are all high. Read data is combinational from the address while select is high with write low.

Top module: `dual_wdt`

## Requirements
- R1: After the asynchronous reset, both counters are stopped, every register reads 0, `wdOut0N` and `wdOut1N` are high and `irq` is low.
- R2: While running and not expired, the narrow counter drops by exactly one per clock, and its live value reads back at offset 0x0C.
- R3: A write to the control register (offset 0x00) with bit 0 set reloads the narrow counter from the reload register at 0x04, sets it running and clears its expiry on that edge. Bit 1 does the same for the wide counter. This happens even when the counter is already running.
- R4: A control write with bit 0 clear (bit 1 clear for the wide counter) stops that counter on the write edge without a further decrement, and the count then holds.
- R5: One clock after the running narrow counter reaches zero, `irq` goes high, `wdOut0N` goes low and status bit 4 of the control register reads 1. With a reload value R written before a start, this is R+1 clocks after the start edge. The condition holds until a reload or restart.
- R6: One clock after the running wide counter reaches zero, `wdOut1N` goes low and status bit 5 reads 1. This holds until a reload or restart, and it does not touch `irq`.
- R7: The wide counter reloads to {reload register at 0x08, 4'b1111}, and offset 0x10 reads its bits 35:4. A reload value V expires 16·V+16 clocks after the start edge.
- R8: Control bits 2 and 3 copy the narrow and wide reload values into the counters and clear their expiry. Bits 0 and 1 still set the run state in the same write.
- R9: Writes to addresses other than 0x00, 0x04 and 0x08 change no register, and such addresses read 0. The reload registers read back what was written, and control bits 0 and 1 read back the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Slave select |
| busEn | input | 1 | Access enable |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, high while the narrow counter is expired |
| wdOut0N | output | 1 | Active-low expiry output of the narrow counter |
| wdOut1N | output | 1 | Active-low reset request from the wide counter |

## Verification
On every cycle the assertions check the per-cycle counter laws: the single-step decrement, the frozen count of a stopped counter, the reload and run state set by a start, the forced low nibble of the wide counter, and that an expiry at zero is followed by the asserted output and then held. Only the bench's scenarios can show the end-to-end periods: expiry exactly R+1 clocks after a start across a sweep of narrow reload values, and 16·V+16 clocks across a sweep of wide ones. The scenarios also show that load strobes clear a parked expiry without starting the counter, that the readback fields line up with the counts, and that unmapped writes leave every register alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register word offsets (byte address / 4)
  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_RELOAD0 = 1;
  localparam int unsigned REG_RELOAD1 = 2;
  localparam int unsigned REG_COUNT0  = 3;
  localparam int unsigned REG_COUNT1  = 4;

  // Control register bit positions
  localparam int unsigned CB_RUN0  = 0;
  localparam int unsigned CB_RUN1  = 1;
  localparam int unsigned CB_LOAD0 = 2;
  localparam int unsigned CB_LOAD1 = 3;
  localparam int unsigned CB_EXP0  = 4;
  localparam int unsigned CB_EXP1  = 5;

  localparam int unsigned NUM_CNT = 2;

  // Strobes from control to datapath, one bit per counter
  typedef struct packed {
    logic [NUM_CNT-1:0] start;
    logic [NUM_CNT-1:0] stop;
    logic [NUM_CNT-1:0] load;
  } wdtStrobes_t;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stop,
  input  logic             load,
  input  logic [WIDTH-1:0] reloadVal,
  output logic [WIDTH-1:0] count,
  output logic             running,
  output logic             expired
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic atZero;
  assign atZero = (count == ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= ZERO;
      running <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      count   <= reloadVal;
      running <= 1'b1;
      expired <= 1'b0;
    end else begin
      if (stop) begin
        running <= 1'b0;
      end
      if (load) begin
        count   <= reloadVal;
        expired <= 1'b0;
      end else if (running && !stop && !expired) begin
        if (atZero) begin
          expired <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FIX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wdtStrobes_t              strobes,
  input  logic [DATA_W-1:0]        reload0,
  input  logic [DATA_W-1:0]        reload1,
  output logic [DATA_W-1:0]        count0,
  output logic [DATA_W+FIX_W-1:0]  count1,
  output logic [NUM_CNT-1:0]       running,
  output logic [NUM_CNT-1:0]       expired
);

  localparam int unsigned CNT1_W = DATA_W + FIX_W;
  localparam logic [FIX_W-1:0] FIX_VAL = '1;

  logic [CNT1_W-1:0] reload1Full;
  assign reload1Full = {reload1, FIX_VAL};

  wdt_counter #(.WIDTH(DATA_W)) u_cnt0 (
    .clk       (clk),
    .rstN      (rstN),
    .start     (strobes.start[0]),
    .stop      (strobes.stop[0]),
    .load      (strobes.load[0]),
    .reloadVal (reload0),
    .count     (count0),
    .running   (running[0]),
    .expired   (expired[0])
  );

  wdt_counter #(.WIDTH(CNT1_W)) u_cnt1 (
    .clk       (clk),
    .rstN      (rstN),
    .start     (strobes.start[1]),
    .stop      (strobes.stop[1]),
    .load      (strobes.load[1]),
    .reloadVal (reload1Full),
    .count     (count1),
    .running   (running[1]),
    .expired   (expired[1])
  );

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busEn,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_CNT-1:0]  running,
  input  logic [NUM_CNT-1:0]  expired,
  input  logic [DATA_W-1:0]   count0,
  input  logic [DATA_W-1:0]   count1Hi,
  output wdtStrobes_t         strobes,
  output logic [DATA_W-1:0]   reload0,
  output logic [DATA_W-1:0]   reload1
);

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(REG_CTRL    * 4);
  localparam logic [ADDR_W-1:0] A_RELOAD0 = ADDR_W'(REG_RELOAD0 * 4);
  localparam logic [ADDR_W-1:0] A_RELOAD1 = ADDR_W'(REG_RELOAD1 * 4);
  localparam logic [ADDR_W-1:0] A_COUNT0  = ADDR_W'(REG_COUNT0  * 4);
  localparam logic [ADDR_W-1:0] A_COUNT1  = ADDR_W'(REG_COUNT1  * 4);

  logic wrAccess;
  logic wrCtrl;
  logic wrReload0;
  logic wrReload1;

  assign wrAccess  = busSel && busEn && busWrite;
  assign wrCtrl    = wrAccess && (busAddr == A_CTRL);
  assign wrReload0 = wrAccess && (busAddr == A_RELOAD0);
  assign wrReload1 = wrAccess && (busAddr == A_RELOAD1);

  // Strobe generation, one lane per counter
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    assign strobes.start[i] = wrCtrl &&  busWdata[CB_RUN0 + i];
    assign strobes.stop[i]  = wrCtrl && !busWdata[CB_RUN0 + i];
    assign strobes.load[i]  = wrCtrl &&  busWdata[CB_LOAD0 + i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reload0 <= '0;
      reload1 <= '0;
    end else begin
      if (wrReload0) reload0 <= busWdata;
      if (wrReload1) reload1 <= busWdata;
    end
  end

  logic [DATA_W-1:0] ctrlRead;
  always_comb begin
    ctrlRead = '0;
    ctrlRead[CB_RUN0] = running[0];
    ctrlRead[CB_RUN1] = running[1];
    ctrlRead[CB_EXP0] = expired[0];
    ctrlRead[CB_EXP1] = expired[1];
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        A_CTRL:    busRdata = ctrlRead;
        A_RELOAD0: busRdata = reload0;
        A_RELOAD1: busRdata = reload1;
        A_COUNT0:  busRdata = count0;
        A_COUNT1:  busRdata = count1Hi;
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FIX_W  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busEn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              wdOut0N,
  output logic              wdOut1N
);

  localparam int unsigned CNT1_W = DATA_W + FIX_W;

  wdtStrobes_t         strobes;
  logic [DATA_W-1:0]   reload0;
  logic [DATA_W-1:0]   reload1;
  logic [DATA_W-1:0]   count0;
  logic [CNT1_W-1:0]   count1;
  logic [NUM_CNT-1:0]  running;
  logic [NUM_CNT-1:0]  expired;

  wdt_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busEn    (busEn),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .running  (running),
    .expired  (expired),
    .count0   (count0),
    .count1Hi (count1[CNT1_W-1 -: DATA_W]),
    .strobes  (strobes),
    .reload0  (reload0),
    .reload1  (reload1)
  );

  wdt_datapath #(.DATA_W(DATA_W), .FIX_W(FIX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reload0 (reload0),
    .reload1 (reload1),
    .count0  (count0),
    .count1  (count1),
    .running (running),
    .expired (expired)
  );

  assign irq     = expired[0];
  assign wdOut0N = ~expired[0];
  assign wdOut1N = ~expired[1];

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FIX_W  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busSel,
  input logic                     busEn,
  input logic                     busWrite,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [DATA_W-1:0]        busWdata,
  input logic                     wdOut0N,
  input logic                     wdOut1N,
  input logic                     irq,
  input logic [DATA_W-1:0]        count0,
  input logic [DATA_W+FIX_W-1:0]  count1,
  input logic [DATA_W-1:0]        reload0,
  input logic [1:0]               running
);

  logic wrCtrl;
  assign wrCtrl = busSel && busEn && busWrite && (busAddr == '0);

  // R2: one step down per clock while running above zero
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (running[0] && count0 != '0 && !wrCtrl) |=> (count0 == $past(count0) - 1));

  // R3: a start write loads the reload value and runs
  a_r3_start_reload: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[0]) |=> (count0 == $past(reload0) && running[0] && wdOut0N));

  // R4: a stopped counter holds its count
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!running[0] && !wrCtrl) |=> $stable(count0));

  // R5: reaching zero while running asserts the narrow outputs next clock
  a_r5_expire_next: assert property (@(posedge clk) disable iff (!rstN)
    (running[0] && count0 == '0 && !wrCtrl) |=> (!wdOut0N && irq));

  // R5: expiry is held until a control write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrCtrl) |=> irq);

  // R6: reset request is held until a control write
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!wdOut1N && !wrCtrl) |=> !wdOut1N);

  // R7: the wide counter restarts with its low nibble all ones
  a_r7_low_ones: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[1]) |=> (count1[FIX_W-1:0] == '1));

endmodule

bind dual_wdt wdt_checker #(.DATA_W(DATA_W), .FIX_W(FIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busEn    (busEn),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .wdOut0N  (wdOut0N),
  .wdOut1N  (wdOut1N),
  .irq      (irq),
  .count0   (count0),
  .count1   (count1),
  .reload0  (reload0),
  .running  (running)
);

// File: tb/sim_dual_wdt.sv
`timescale 1ns/1ps
module sim_dual_wdt;

  localparam int CLK_PERIOD = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busEn = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic        wdOut0N;
  logic        wdOut1N;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wdt u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEn(busEn), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .wdOut0N(wdOut0N), .wdOut1N(wdOut1N)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busEn = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busEn = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // Counts clocks until the selected active-low output drops
  task automatic measure(input bit wide, input int limit, output int n);
    n = 0;
    while (((wide ? wdOut1N : wdOut0N) == 1'b1) && n < limit) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;

    #(CLK_PERIOD*2 + 1);
    @(negedge clk);
    // R1 reset state
    check("R1", "wdOut0N", wdOut0N, 1);
    check("R1", "wdOut1N", wdOut1N, 1);
    check("R1", "irq", irq, 0);
    for (int a = 0; a < 5; a++) begin
      busRd(5'(a*4), rd);
      check("R1", "reg after reset", rd, 0);
    end
    rstN = 1'b1;
    idle(2);

    // R2/R4: decrement and stop
    busWr(5'h04, 32'd100);
    busRd(5'h04, rd); check("R9", "reload0 readback", rd, 100);
    busWr(5'h00, 32'h1);
    busRd(5'h0C, rd); check("R3", "count0 after start", rd, 100);
    busRd(5'h00, rd); check("R9", "run0 bit", rd, 32'h1);
    idle(7);
    busRd(5'h0C, rd); check("R2", "count0 after 7 clocks", rd, 93);
    busWr(5'h00, 32'h0);
    busRd(5'h0C, rd); check("R4", "count0 on stop edge", rd, 93);
    idle(5);
    busRd(5'h0C, rd); check("R4", "count0 held", rd, 93);
    busWr(5'h00, 32'h1);
    busRd(5'h0C, rd); check("R3", "restart value", rd, 100);
    idle(3);
    busWr(5'h00, 32'h1);
    busRd(5'h0C, rd); check("R3", "restart while running", rd, 100);
    busWr(5'h00, 32'h0);

    // R5 sweep of narrow reloads
    for (int r = 0; r < 8; r++) begin
      busWr(5'h04, 32'(r));
      busWr(5'h00, 32'h1);
      measure(1'b0, 64, n);
      check("R5", "narrow expiry latency", n, r + 1);
      check("R5", "irq on expiry", irq, 1);
      busRd(5'h00, rd); check("R5", "status exp0", rd[4], 1);
      check("R6", "wide untouched", wdOut1N, 1);
      idle(6);
      check("R5", "expiry held", wdOut0N, 0);
      busRd(5'h0C, rd); check("R5", "parked at zero", rd, 0);
    end

    // R8 load while stopped: clears expiry, no start
    busWr(5'h04, 32'd20);
    busWr(5'h00, 32'h4);
    check("R8", "expiry cleared by load", wdOut0N, 1);
    check("R8", "irq cleared by load", irq, 0);
    idle(4);
    busRd(5'h0C, rd); check("R8", "loaded but stopped", rd, 20);
    busRd(5'h00, rd); check("R8", "status after load", rd, 0);
    // load together with run bit: runs from reload
    busWr(5'h00, 32'h5);
    idle(2);
    busRd(5'h0C, rd); check("R8", "load with run", rd, 18);
    busWr(5'h00, 32'h0);

    // R7/R6 sweep of wide reloads
    for (int v = 0; v < 4; v++) begin
      busWr(5'h08, 32'(v));
      busWr(5'h00, 32'h2);
      busRd(5'h10, rd); check("R7", "count1 upper field after start", rd, v);
      measure(1'b1, 200, n);
      check("R7", "wide expiry latency", n, 16*v + 16);
      busRd(5'h00, rd); check("R6", "status exp1", rd[5], 1);
      check("R6", "irq not driven by wide", irq, 0);
      idle(5);
      check("R6", "reset request held", wdOut1N, 0);
    end
    busWr(5'h08, 32'd3);
    busWr(5'h00, 32'h2);
    check("R6", "restart clears request", wdOut1N, 1);
    idle(16);
    busRd(5'h10, rd); check("R7", "count1 field after 16 clocks", rd, 2);
    busWr(5'h00, 32'h8);
    busRd(5'h10, rd); check("R8", "wide load stopped", rd, 3);
    idle(3);
    busRd(5'h10, rd); check("R8", "wide held after load", rd, 3);

    // R9 unmapped addresses
    busWr(5'h14, 32'hFFFF_FFFF);
    busWr(5'h0C, 32'h1234);
    busWr(5'h1C, 32'h3);
    busRd(5'h14, rd); check("R9", "unmapped read", rd, 0);
    busRd(5'h04, rd); check("R9", "reload0 untouched", rd, 20);
    busRd(5'h08, rd); check("R9", "reload1 untouched", rd, 3);
    busRd(5'h0C, rd); check("R9", "count0 untouched", rd, 18);
    busRd(5'h00, rd); check("R9", "ctrl untouched", rd, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule